// File: doc/BRIEF.md
# Enabled-Channel Conversion Scan Sequencer

This block drives an external converter across a bank of analog channels. Each channel has its own enable bit. A pulse on `en_set` turns the selected bits on and a pulse on `en_clr` turns them off. One `start` pulse captures the enabled set and then converts each captured channel in turn, lowest index first. For each channel the block raises a convert request, waits for the converter's done strobe and offers the result on a valid/ready stream, tagged with the channel number. When the last captured channel has been accepted, the block pulses `eos` for one cycle and goes back to idle.

In dual-trigger mode the highest channel is left out of the main scan. It is converted only when its own trigger, `last_trig`, arrives. If that trigger comes while a scan is running, it is held pending. The top channel is converted as soon as the result in flight has been accepted, and the scan then continues where it stopped.

Back-pressure rules for the result stream:
- While `out_valid` is high and `out_ready` is low, the block holds `out_ch` and `out_data` unchanged.
- The block starts no new conversion until the consumer takes the pending result.
- A beat transfers on any rising edge where `out_valid` and `out_ready` are both high.

Top module: `scan_sequencer`

## Requirements
- R1: The enable mask is updated one cycle after an `en_set` or `en_clr` pulse: bits set in `en_set` turn on and bits set in `en_clr` turn off. A bit set in both in the same cycle ends up off. `en_mask` shows the current mask.
- R2: One `start` pulse in idle converts every channel in the scan set with no further command. Channels are visited in ascending index. Each request is held, with a stable `cnv_ch`, until `cnv_done`.
- R3: The scan set is captured when the scan starts. Disabled channels produce no request and no output beat. Changing the enables during a scan does not alter that scan.
- R4: After the final result is accepted, `busy` falls and the block waits idle. A later `start` runs a fresh scan.
- R5: A `start` while `busy` is high is ignored and sets `overrun`. `ovr_clr` clears `overrun`; a set in the same cycle wins.
- R6: Each result beat carries the channel number on `out_ch` (4 bits at default size) and the 12-bit converter value on `out_data`. Both stay stable while `out_valid` is high and `out_ready` is low.
- R7: `eos` is high for exactly one cycle per main scan, right after the final scan result is accepted.
- R8: With `dual_mode` high, the top channel is not part of the main scan. It is converted once per `last_trig` pulse, provided it is enabled, and its beat does not raise `eos`. With `dual_mode` low, `last_trig` has no effect.
- R9: A `last_trig` that arrives during a scan is held pending. The top channel is converted right after the current channel's result is accepted, and the scan then resumes in order.
- R10: A `start` whose scan set is empty produces no request, no beat, no `eos` and no `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | NCH | One-cycle set pulses for channel enables |
| en_clr | input | NCH | One-cycle clear pulses for channel enables |
| en_mask | output | NCH | Current enable mask |
| dual_mode | input | 1 | Top channel runs on its own trigger |
| start | input | 1 | Start a main scan |
| last_trig | input | 1 | Trigger for the top channel in dual mode |
| ovr_clr | input | 1 | Clear the overrun flag |
| busy | output | 1 | A conversion or result is in progress |
| overrun | output | 1 | A start was dropped while busy |
| eos | output | 1 | One-cycle end-of-scan pulse |
| cnv_req | output | 1 | Convert request, held until done |
| cnv_ch | output | CW | Channel to convert |
| cnv_done | input | 1 | Converter finished; data valid |
| cnv_data | input | RW | Converter result |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_ch | output | CW | Channel tag of the beat |
| out_data | output | RW | Result of the beat |

## Verification
A corrupted remaining-channel set shows up at the ports within one conversion: a channel is missing, repeated or out of order in the beat list, or `eos` is missing or doubled. A lost or stuck pending flag for the top channel moves its beat out of the slot right after the current result, or makes it appear with no trigger. Broken stall handling changes `out_ch` or `out_data` while a beat waits for `out_ready`, which is visible in the next cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_PUSH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sq_enable_reg.sv
module sq_enable_reg #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) mask_o <= '0;
    else        mask_o <= (mask_o | set_i) & ~clr_i;
  end

  // R1: a cleared bit is off on the next cycle, even if also set
  a_r1_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((mask_o & $past(clr_i)) == '0));
endmodule

// File: rtl/sq_lowest.sv
module sq_lowest #(
  parameter int NCH = 16,
  parameter int CW  = 4
) (
  input  logic [NCH-1:0] vec_i,
  output logic [CW-1:0]  idx_o,
  output logic           any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = CW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int NCH = 16,
  parameter int RW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en_set,
  input  logic [NCH-1:0] en_clr,
  output logic [NCH-1:0] en_mask,
  input  logic           dual_mode,
  input  logic           start,
  input  logic           last_trig,
  input  logic           ovr_clr,
  output logic           busy,
  output logic           overrun,
  output logic           eos,
  output logic           cnv_req,
  output logic [CW-1:0]  cnv_ch,
  input  logic           cnv_done,
  input  logic [RW-1:0]  cnv_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [CW-1:0]  out_ch,
  output logic [RW-1:0]  out_data
);
  localparam int TOP = NCH - 1;
  localparam logic [NCH-1:0] TOP_BIT = NCH'(1) << TOP;

  seq_state_e     state_q;
  logic [NCH-1:0] en_q, remain_q, remain_nx, start_mask;
  logic           pend_q, cur_top_q, ovr_q, eos_q;
  logic [CW-1:0]  cur_ch_q, low_idx;
  logic           low_any;
  logic [RW-1:0]  res_q;
  logic           idle, accept, start_ok, launch, launch_top, pend_set;

  sq_enable_reg #(.NCH(NCH)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .mask_o (en_q)
  );

  assign idle       = (state_q == ST_IDLE);
  assign accept     = (state_q == ST_PUSH) && out_ready;
  assign start_mask = dual_mode ? (en_q & ~TOP_BIT) : en_q;
  assign start_ok   = idle && start && (|start_mask);
  assign launch     = idle || accept;
  assign launch_top = launch && pend_q;
  assign pend_set   = dual_mode && last_trig && en_q[TOP];

  // channels still owed in the current scan, after this cycle's events
  always_comb begin
    remain_nx = remain_q;
    if (accept && !cur_top_q) remain_nx[cur_ch_q] = 1'b0;
    if (start_ok)             remain_nx = start_mask;
  end

  sq_lowest #(.NCH(NCH), .CW(CW)) u_pick (
    .vec_i (remain_nx),
    .idx_o (low_idx),
    .any_o (low_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      remain_q  <= '0;
      pend_q    <= 1'b0;
      cur_top_q <= 1'b0;
      cur_ch_q  <= '0;
      res_q     <= '0;
      ovr_q     <= 1'b0;
      eos_q     <= 1'b0;
    end else begin
      if (state_q == ST_CONV && cnv_done) begin
        res_q   <= cnv_data;
        state_q <= ST_PUSH;
      end
      if (launch) begin
        if (pend_q) begin
          state_q   <= ST_CONV;
          cur_ch_q  <= CW'(TOP);
          cur_top_q <= 1'b1;
        end else if (low_any) begin
          state_q   <= ST_CONV;
          cur_ch_q  <= low_idx;
          cur_top_q <= 1'b0;
        end else begin
          state_q   <= ST_IDLE;
        end
      end
      remain_q <= remain_nx;
      pend_q   <= (pend_q && !launch_top) || pend_set;
      if (start && !idle) ovr_q <= 1'b1;
      else if (ovr_clr)   ovr_q <= 1'b0;
      eos_q <= accept && !cur_top_q && !(|remain_nx);
    end
  end

  assign en_mask   = en_q;
  assign busy      = !idle;
  assign overrun   = ovr_q;
  assign eos       = eos_q;
  assign cnv_req   = (state_q == ST_CONV);
  assign cnv_ch    = cur_ch_q;
  assign out_valid = (state_q == ST_PUSH);
  assign out_ch    = cur_ch_q;
  assign out_data  = res_q;

  // R2: request held with a stable channel until the converter answers
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_req && !cnv_done) |=> (cnv_req && $stable(cnv_ch)));
  // R3: a main-scan beat only for a channel still owed in this scan
  a_r3_scan_member: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cur_top_q) |-> remain_q[out_ch]);
  // R5: a start seen while busy raises overrun
  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> overrun);
  // R6: stalled beat keeps its content
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ch) && $stable(out_data)));
  // R7: end-of-scan is a single-cycle pulse
  a_r7_eos_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> !eos);
  // R8: the top channel is requested from the trigger path only in dual mode
  a_r8_top_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_req && cur_top_q) |-> (cnv_ch == CW'(TOP)));
endmodule

// File: tb/scan_sequencer_bench.sv
`timescale 1ns/1ps
module scan_sequencer_bench;
  localparam int NCH = 16;
  localparam int RW  = 12;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] en_set = '0, en_clr = '0, en_mask;
  logic dual_mode = 1'b0, start = 1'b0, last_trig = 1'b0, ovr_clr = 1'b0;
  logic busy, overrun, eos, cnv_req, cnv_done, out_valid, out_ready;
  logic [CW-1:0] cnv_ch, out_ch;
  logic [RW-1:0] cnv_data, out_data;

  int checks = 0, fails = 0, cyc = 0;
  int rec_n = 0, eos_n = 0, rcnt = 0;
  int rec_ch [64];
  int rec_d  [64];
  int exp_ch [64];
  int exp_n;
  bit stall = 1'b0;

  always #2.5 clk = ~clk;

  scan_sequencer u_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr), .en_mask(en_mask),
    .dual_mode(dual_mode), .start(start), .last_trig(last_trig), .ovr_clr(ovr_clr),
    .busy(busy), .overrun(overrun), .eos(eos), .cnv_req(cnv_req), .cnv_ch(cnv_ch),
    .cnv_done(cnv_done), .cnv_data(cnv_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_ch(out_ch), .out_data(out_data)
  );

  function automatic int conv_val(int ch);
    return (ch * 37 + 5) & 12'hFFF;
  endfunction

  // converter model: answers one cycle after a request is seen
  always @(posedge clk) begin
    if (!rst_n) begin
      cnv_done <= 1'b0;
      cnv_data <= '0;
    end else begin
      cnv_done <= cnv_req && !cnv_done;
      cnv_data <= RW'(conv_val(int'(cnv_ch)));
    end
  end

  always @(posedge clk) begin
    #1;
    rcnt++;
    out_ready = !stall || (rcnt % 3 == 0);
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rec_n < 64) begin
      rec_ch[rec_n] = int'(out_ch);
      rec_d[rec_n]  = int'(out_data);
      rec_n++;
    end
    if (rst_n && eos) eos_n++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic load_mask(input logic [NCH-1:0] m);
    en_clr = '1; step(1);
    en_clr = '0; en_set = m; step(1);
    en_set = '0;
  endtask

  task automatic clear_log();
    rec_n = 0;
    eos_n = 0;
  endtask

  task automatic pulse_start();
    start = 1'b1; step(1);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    step(1);
    @(negedge clk);
    while (busy) @(negedge clk);
    step(3);
  endtask

  task automatic build_exp(input logic [NCH-1:0] m, input bit dual);
    exp_n = 0;
    for (int i = 0; i < NCH; i++)
      if (m[i] && !(dual && i == NCH - 1)) begin
        exp_ch[exp_n] = i;
        exp_n++;
      end
  endtask

  task automatic compare_log(input string req);
    check(rec_n == exp_n, req, rec_n, exp_n);
    for (int k = 0; k < exp_n && k < rec_n; k++) begin
      check(rec_ch[k] == exp_ch[k], req, rec_ch[k], exp_ch[k]);
      check(rec_d[k] == conv_val(exp_ch[k]), "R6", rec_d[k], conv_val(exp_ch[k]));
    end
  endtask

  // {stall, dual, mask}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b0, 16'h0001},
    {1'b0, 1'b0, 16'hFFFF},
    {1'b1, 1'b0, 16'h8421},
    {1'b0, 1'b1, 16'hA5A5},
    {1'b1, 1'b0, 16'h8000},
    {1'b1, 1'b1, 16'hFFFF},
    {1'b0, 1'b0, 16'h0F0F},
    {1'b1, 1'b1, 16'h7FFE}
  };

  initial begin
    step(3);
    // reset state
    check(en_mask == '0, "R1", int'(en_mask), 0);
    check(!busy && !out_valid && !cnv_req, "R4", {busy, out_valid, cnv_req}, 0);
    check(!overrun && !eos, "R5", {overrun, eos}, 0);
    rst_n = 1'b1;
    step(2);

    // R2 R3 R4 R6 R7 R8: vector table
    for (int v = 0; v < 8; v++) begin
      stall     = VEC[v][17];
      dual_mode = VEC[v][16];
      load_mask(VEC[v][15:0]);
      clear_log();
      build_exp(VEC[v][15:0], VEC[v][16]);
      pulse_start();
      wait_idle();
      compare_log("R2");
      check(eos_n == 1, "R7", eos_n, 1);
      check(!overrun, "R4", overrun, 0);
    end
    stall = 1'b0;
    dual_mode = 1'b0;

    // R1: set and clear in the same cycle, clear wins
    en_clr = '1; step(1);
    en_clr = 16'h0010; en_set = 16'h00F0; step(1);
    en_clr = '0; en_set = '0;
    @(negedge clk);
    check(en_mask == 16'h00E0, "R1", int'(en_mask), 16'h00E0);
    step(1);

    // R10: empty scan set
    load_mask('0);
    clear_log();
    pulse_start();
    step(6);
    check(rec_n == 0 && eos_n == 0, "R10", rec_n + eos_n, 0);
    check(!overrun && !busy, "R10", {overrun, busy}, 0);
    // R10: dual mode with only the top channel enabled
    dual_mode = 1'b1;
    load_mask(16'h8000);
    clear_log();
    pulse_start();
    step(6);
    check(rec_n == 0 && eos_n == 0, "R10", rec_n + eos_n, 0);
    dual_mode = 1'b0;

    // R3: enables changed mid-scan do not alter the scan
    stall = 1'b1;
    load_mask(16'h000F);
    clear_log();
    build_exp(16'h000F, 1'b0);
    pulse_start();
    en_clr = '1; step(1);
    en_clr = '0; en_set = 16'h00F0; step(1);
    en_set = '0;
    wait_idle();
    compare_log("R3");
    check(en_mask == 16'h00F0, "R3", int'(en_mask), 16'h00F0);

    // R5: start while busy is dropped and flags overrun
    load_mask(16'h0306);
    clear_log();
    build_exp(16'h0306, 1'b0);
    pulse_start();
    step(2);
    pulse_start();
    wait_idle();
    compare_log("R5");
    check(overrun, "R5", overrun, 1);
    check(eos_n == 1, "R5", eos_n, 1);
    ovr_clr = 1'b1; step(1);
    ovr_clr = 1'b0;
    @(negedge clk);
    check(!overrun, "R5", overrun, 0);
    stall = 1'b0;

    // R8: top channel on its own trigger, no eos
    dual_mode = 1'b1;
    load_mask(16'h800F);
    clear_log();
    last_trig = 1'b1; step(1);
    last_trig = 1'b0;
    wait_idle();
    check(rec_n == 1, "R8", rec_n, 1);
    check(rec_ch[0] == 15, "R8", rec_ch[0], 15);
    check(eos_n == 0, "R8", eos_n, 0);
    // R8: trigger ignored outside dual mode
    dual_mode = 1'b0;
    clear_log();
    last_trig = 1'b1; step(1);
    last_trig = 1'b0;
    step(6);
    check(rec_n == 0 && !busy, "R8", rec_n, 0);

    // R9: trigger during a scan is serviced after the current beat
    dual_mode = 1'b1;
    stall = 1'b1;
    clear_log();
    pulse_start();
    @(negedge clk);
    while (rec_n < 1) @(negedge clk);
    @(posedge clk); #1;
    last_trig = 1'b1; step(1);
    last_trig = 1'b0;
    wait_idle();
    exp_n = 5;
    exp_ch[0] = 0; exp_ch[1] = 1; exp_ch[2] = 15; exp_ch[3] = 2; exp_ch[4] = 3;
    compare_log("R9");
    check(eos_n == 1, "R9", eos_n, 1);
    stall = 1'b0;
    dual_mode = 1'b0;

    // R4: a fresh scan runs after idle
    load_mask(16'h0042);
    clear_log();
    build_exp(16'h0042, 1'b0);
    pulse_start();
    wait_idle();
    compare_log("R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule